// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the ordered stream of column addresses that a memory controller issues across a single row. A pulse on the start input captures a starting column, a burst-length code and an ordering select. From the next cycle on, the block presents one column address per clock with a valid flag, and it raises a last-beat flag on the final beat of a fixed-length burst.

Fixed bursts stay inside the aligned block of 2, 4 or 8 columns that holds the starting column. Within that block the order is either sequential (count up with wrap) or interleaved (start offset XOR beat number). The full-row mode walks upward through every column with wrap-around and runs until a stop pulse ends it. A new start always restarts the sequence, even in the middle of a burst.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high at a clock edge, the block is idle after that edge: `vld` and `last` read 0.
- R2: In the cycle after an edge that samples `start` high, `vld` is 1 and `col` equals the `start_col` sampled at that edge, for every length and ordering.
- R3: The burst-length code `blen` selects the beat count: 0 gives 2 beats, 1 gives 4 beats, 2 gives 8 beats and 3 gives full-row mode. A fixed burst keeps `vld` high for exactly that many cycles, then `vld` drops.
- R4: With `ilv` = 0, beat i of a fixed burst of N beats has the address (S with its low log2(N) bits cleared) plus ((S + i) mod N), where S is the starting column.
- R5: With `ilv` = 1, beat i of a fixed burst of N beats has the address (S with its low log2(N) bits cleared) plus ((S mod N) XOR i).
- R6: In full-row mode, beat i is (S + i) mod 1024. The mode continues until stopped or restarted, and `ilv` has no effect.
- R7: `last` is 1 only on the final beat of a fixed burst, and it is never 1 in full-row mode.
- R8: When `stop` is high at an edge without `start`, `vld` and `last` are 0 from the next cycle on. A stop while idle has no effect.
- R9: A `start` during an active burst restarts from the new parameters in the next cycle. When `start` and `stop` are high together, `start` wins.
- R10: `start_col`, `blen` and `ilv` are sampled only at a start. Changes to them during a burst leave the running sequence unchanged.
- R11: During a fixed burst, the column bits above the burst block never change from beat to beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a burst with the parameters sampled on this edge |
| start_col | input | 10 | Starting column address |
| blen | input | 2 | Length code: 0 = 2, 1 = 4, 2 = 8 beats, 3 = full row |
| ilv | input | 1 | Ordering: 0 = sequential, 1 = interleaved |
| stop | input | 1 | Terminate the running burst |
| vld | output | 1 | A column address is presented this cycle |
| col | output | 10 | Current column address |
| last | output | 1 | Final beat of a fixed-length burst |

## Verification
Every result is due exactly one edge after the stimulus that causes it. Beat 0 appears in the cycle after the start edge, each later beat follows one edge after the one before it, and `vld` falls one edge after the final beat or after a stop. The bench drives inputs at the falling edge. A behavioural model, built from queues of precomputed beat addresses, is updated at the same rising edge as the design. Each falling edge compares `vld`, `last` and, while valid, `col` against that model, so every check lands in the cycle where the requirement says the value is due.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       blen,
  input  logic             ilv,
  input  logic             stop,
  output logic             vld,
  output logic [COL_W-1:0] col,
  output logic             last
);

  logic             act_q, ilv_q, page_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic [COL_W-1:0] mask_d, low;

  always_comb begin
    case (blen)
      2'd0:    mask_d = COL_W'(1);
      2'd1:    mask_d = COL_W'(3);
      2'd2:    mask_d = COL_W'(7);
      default: mask_d = '1;
    endcase
  end

  assign last = act_q && !page_q && (cnt_q == mask_q);
  assign vld  = act_q;
  assign low  = ilv_q ? (base_q ^ cnt_q) : (base_q + cnt_q);
  assign col  = (base_q & ~mask_q) | (low & mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      ilv_q  <= 1'b0;
      page_q <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      base_q <= start_col;
      cnt_q  <= '0;
      mask_q <= mask_d;
      page_q <= (blen == 2'd3);
      ilv_q  <= ilv && (blen != 2'd3);
    end else if (act_q) begin
      if (stop || last) act_q <= 1'b0;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!vld && !last));

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (vld && col == $past(start_col)));

  // R3
  end_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (last && !start) |=> !vld);

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> (!vld && !last));

  // R6
  page_step_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && page_q && !start && !stop) |=> (vld && col == COL_W'($past(col) + 1'b1)));

  // R7
  last_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    last |-> (vld && !page_q));

  // R11
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && !page_q && !start && !stop && !last) |=>
      (vld && (col & ~mask_q) == ($past(col) & ~mask_q)));

endmodule

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/100ps
module burst_col_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, ilv = 1'b0, stop = 1'b0;
  logic [9:0] start_col = '0;
  logic [1:0] blen = '0;
  logic       vld, last;
  logic [9:0] col;

  int    checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  int q[$];
  bit fp = 0;
  int fpcol = 0;

  always #2.5 clk = ~clk;

  burst_col_gen u_dut (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col), .blen(blen),
    .ilv(ilv), .stop(stop), .vld(vld), .col(col), .last(last)
  );

  function automatic void load(int s, int bl, bit il);
    q.delete();
    if (bl == 3) begin
      fp = 1; fpcol = s;
    end else begin
      int n = 2 << bl;
      fp = 0;
      for (int i = 0; i < n; i++) begin
        int lo = il ? (s ^ i) : (s + i);
        q.push_back((s & ~(n - 1)) | (lo & (n - 1)));
      end
    end
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      q.delete(); fp = 0;
    end else if (start) begin
      load(int'(start_col), int'(blen), ilv);
    end else if (stop) begin
      q.delete(); fp = 0;
    end else if (fp) begin
      fpcol = (fpcol + 1) % 1024;
    end else if (q.size() > 0) begin
      void'(q.pop_front());
    end
  end

  task automatic compare();
    bit ev, el;
    int ec;
    ev = fp || (q.size() > 0);
    el = !fp && (q.size() == 1);
    ec = fp ? fpcol : (q.size() > 0 ? q[0] : 0);
    checks++;
    if (vld !== ev || last !== el || (ev && int'(col) != ec)) begin
      fails++;
      $display("FAIL %s: vld=%0b col=%03h last=%0b expected vld=%0b col=%03h last=%0b",
               tag, vld, col, last, ev, ec[9:0], el);
    end
  endtask

  task automatic cyc(bit s, int c, int bl, bit il, bit sp);
    start = s; start_col = 10'(c); blen = 2'(bl); ilv = il; stop = sp;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic burst(string t, int s, int bl, bit il);
    tag = t;
    cyc(1, s, bl, il, 0);
    idle((2 << bl) + 2);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    compare();

    burst("R4 R3 R7 R11 sequential", 10'h3F5, 2, 0);
    burst("R4 R3 R7 sequential", 10'h002, 1, 0);
    burst("R4 R3 R2 sequential", 10'h001, 0, 0);
    burst("R5 R3 R7 R11 interleaved", 10'h0A6, 2, 1);
    burst("R5 R2 interleaved", 10'h3F1, 1, 1);
    burst("R5 R7 interleaved", 10'h3FF, 0, 1);

    tag = "R10 inputs ignored mid-burst";
    cyc(1, 10'h105, 1, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 10'h000, 3, 1, 0);

    tag = "R6 R7 full row wrap";
    cyc(1, 10'h3FC, 3, 1, 0);
    idle(12);
    tag = "R8 stop full row";
    cyc(0, 0, 0, 0, 1);
    idle(3);

    tag = "R8 stop mid-burst";
    cyc(1, 10'h040, 2, 0, 0);
    idle(3);
    cyc(0, 0, 0, 0, 1);
    idle(3);
    tag = "R8 stop while idle";
    cyc(0, 0, 0, 0, 1);
    idle(2);

    tag = "R9 restart mid-burst";
    cyc(1, 10'h010, 2, 0, 0);
    idle(2);
    cyc(1, 10'h2A3, 1, 1, 0);
    idle(6);
    tag = "R9 start beats stop";
    cyc(1, 10'h155, 2, 1, 0);
    idle(1);
    cyc(1, 10'h0FE, 0, 0, 1);
    idle(4);

    tag = "R1 reset mid-burst";
    cyc(1, 10'h200, 3, 0, 0);
    idle(2);
    rst = 1'b1;
    cyc(0, 0, 0, 0, 0);
    rst = 1'b0;
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++;
    $display("FAIL watchdog: cycles=%0d expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule